// File: doc/BRIEF.md
# Field Parity Detector from Sync Phase

This block sits behind the sync inputs of a video encoder that runs as a timing slave. It takes active-low horizontal and vertical sync pins and samples them on the internal pixel clock. From where the vertical sync falling edge lands in the horizontal line, it decides whether the field that is starting is odd or even. Both pins are re-registered before any edge is looked at. The skew between the two falling edges is measured on those registered copies.

A field counts as odd only in one case: vertical sync falls together with horizontal sync, or at most two clocks before it. Every other alignment gives an even field. This includes the usual interlaced even case, where vertical sync falls near mid-line, and it includes a vertical sync with no horizontal fall close behind. A vertical pulse counts only once it has stayed low long enough. When that qualification completes, the new field flag is loaded and a one-clock field-start strobe goes to the downstream timing generator. A shorter vertical pulse is ignored.

Top module: `fdet_field_detect`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `field_start` is 0 and `field_odd` is 0, where 0 means even and 1 means odd.
- R2: A field is odd when the first low HSY sample is taken 0, 1 or ODD_LEAD_MAX samples after the first low VSY sample. ODD_LEAD_MAX defaults to 2.
- R3: Every other alignment classifies the field as even. This covers a HSY fall before the VSY fall, a HSY fall more than ODD_LEAD_MAX samples after it, a mid-line VSY fall, and no HSY fall at all.
- R4: A VSY low run qualifies once VS_MIN_LOW consecutive low samples have been taken (default 128). `field_start` is then high for exactly one cycle, starting at the second rising edge after the VS_MIN_LOW-th low sample.
- R5: Exactly one `field_start` pulse is issued for each qualifying VSY low run, however long the run lasts.
- R6: A VSY low run shorter than VS_MIN_LOW samples issues no `field_start` and leaves `field_odd` unchanged.
- R7: `field_odd` changes value only at the edge where `field_start` rises. It holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal pixel clock; the sync pins are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| hsync_n | input | 1 | Horizontal sync, active low |
| vsync_n | input | 1 | Vertical sync, active low |
| field_odd | output | 1 | Parity of the current field: 1 for odd, 0 for even |
| field_start | output | 1 | One-cycle strobe when a new field has been qualified |

## Verification
The hardest case to reach is the edge of the skew window. A VSY fall exactly ODD_LEAD_MAX samples ahead of the HSY fall must give odd, and one sample further out must give even. A run of VS_MIN_LOW-1 low samples must also be reached, so that it can be shown to change nothing. The stimulus keeps a free-running line-phase counter and places each VSY fall at a chosen signed offset from the next HSY fall. Directed fields hit offsets 0, 1, 2, 3, -1 and mid-line, with low lengths of 127, 128 and longer than a line. Random fields then spread the offset over the whole line and the length around the threshold. A short pulse is placed straight after an odd field and after an even field, each with an alignment that would flip the flag, so that a held flag can be seen.

// File: rtl/fdet_pkg.sv
package fdet_pkg;

    typedef enum logic {
        FIELD_EVEN = 1'b0,
        FIELD_ODD  = 1'b1
    } field_e;

    // Registered view of one active-low sync pin
    typedef struct packed {
        logic fall;   // first cycle of a low level
        logic low;    // registered level is low
    } sync_ev_t;

    function automatic int unsigned cnt_width(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/fdet_sync_edge.sv
module fdet_sync_edge
    import fdet_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pin_n,
    output sync_ev_t ev
);
    logic [STAGES-1:0] stage_q;
    logic              last_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= 1'b1;
                    else     stage_q[0] <= pin_n;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= 1'b1;
                    else     stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b1;
        else     last_q <= stage_q[STAGES-1];
    end

    always_comb begin
        ev.low  = ~stage_q[STAGES-1];
        ev.fall = last_q & ~stage_q[STAGES-1];
    end
endmodule

// File: rtl/fdet_skew_window.sv
module fdet_skew_window
    import fdet_pkg::*;
#(
    parameter int unsigned LEAD_MAX = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  sync_ev_t h_ev,
    input  sync_ev_t v_ev,
    output field_e   parity
);
    localparam int unsigned CW = cnt_width(LEAD_MAX);
    localparam logic [CW-1:0] LAST = CW'(LEAD_MAX);

    logic          armed_q;
    logic [CW-1:0] dist_q;
    field_e        parity_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q  <= 1'b0;
            dist_q   <= '0;
            parity_q <= FIELD_EVEN;
        end else if (v_ev.fall) begin
            dist_q   <= CW'(1);
            armed_q  <= !h_ev.fall && (LEAD_MAX > 0);
            parity_q <= h_ev.fall ? FIELD_ODD : FIELD_EVEN;
        end else if (armed_q) begin
            if (h_ev.fall) begin
                parity_q <= FIELD_ODD;
                armed_q  <= 1'b0;
            end else if (dist_q == LAST) begin
                armed_q  <= 1'b0;
            end else begin
                dist_q   <= dist_q + CW'(1);
            end
        end
    end

    assign parity = parity_q;
endmodule

// File: rtl/fdet_vqual.sv
module fdet_vqual
    import fdet_pkg::*;
#(
    parameter int unsigned MIN_LOW = 128
) (
    input  logic     clk,
    input  logic     rst,
    input  sync_ev_t v_ev,
    output logic     qualified
);
    localparam int unsigned CW = cnt_width(MIN_LOW);
    localparam logic [CW-1:0] TOP  = CW'(MIN_LOW);
    localparam logic [CW-1:0] LAST = CW'(MIN_LOW - 1);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst || !v_ev.low) run_q <= '0;
        else if (run_q != TOP) run_q <= run_q + CW'(1);
    end

    assign qualified = v_ev.low && (run_q == LAST);
endmodule

// File: rtl/fdet_field_detect.sv
module fdet_field_detect
    import fdet_pkg::*;
#(
    parameter int unsigned VS_MIN_LOW   = 128,
    parameter int unsigned ODD_LEAD_MAX = 2,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic hsync_n,
    input  logic vsync_n,
    output logic field_odd,
    output logic field_start
);
    sync_ev_t h_ev;
    sync_ev_t v_ev;
    field_e   pend_parity;
    field_e   field_q;
    logic     qual;
    logic     start_q;

    fdet_sync_edge #(.STAGES(SYNC_STAGES)) u_hsync (
        .clk(clk), .rst(rst), .pin_n(hsync_n), .ev(h_ev)
    );

    fdet_sync_edge #(.STAGES(SYNC_STAGES)) u_vsync (
        .clk(clk), .rst(rst), .pin_n(vsync_n), .ev(v_ev)
    );

    fdet_skew_window #(.LEAD_MAX(ODD_LEAD_MAX)) u_window (
        .clk(clk), .rst(rst), .h_ev(h_ev), .v_ev(v_ev), .parity(pend_parity)
    );

    fdet_vqual #(.MIN_LOW(VS_MIN_LOW)) u_qual (
        .clk(clk), .rst(rst), .v_ev(v_ev), .qualified(qual)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            field_q <= FIELD_EVEN;
            start_q <= 1'b0;
        end else begin
            start_q <= qual;
            if (qual) field_q <= pend_parity;
        end
    end

    assign field_odd   = (field_q == FIELD_ODD);
    assign field_start = start_q;
endmodule

// File: rtl/fdet_checker.sv
module fdet_checker (
    input logic clk,
    input logic rst,
    input logic vsync_n,
    input logic field_odd,
    input logic field_start
);
    logic [1:0] age_q;

    always_ff @(posedge clk) begin
        if (rst) age_q <= 2'd0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!field_start && !field_odd)); // R1

    AST_START_VLOW: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd3 && field_start) |-> ($past(vsync_n, 3) == 1'b0)); // R4

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
        field_start |=> !field_start); // R5

    AST_FLAG_WITH_START: assert property (@(posedge clk) disable iff (rst)
        (age_q != 2'd0 && field_odd != $past(field_odd)) |-> field_start); // R7
endmodule

bind fdet_field_detect fdet_checker u_fdet_checker (
    .clk(clk), .rst(rst), .vsync_n(vsync_n),
    .field_odd(field_odd), .field_start(field_start)
);

// File: tb/tb_fdet_field_detect.sv
module tb_fdet_field_detect;
    localparam int LINE  = 300;
    localparam int HW    = 64;
    localparam int VMIN  = 128;
    localparam int LEAD  = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hsync_n = 1'b1;
    logic vsync_n = 1'b1;
    logic field_odd, field_start;

    int n_chk = 0;
    int n_bad = 0;
    int ph = 0;
    int starts_seen = 0;
    logic exp_flag = 1'b0;

    // cycle model state, built from the requirements
    logic m_hprev = 1'b1, m_vprev = 1'b1, m_pend = 1'b0, m_flag = 1'b0;
    int   m_since = 1000, m_vrun = 0;
    logic q_start [3];
    logic q_odd   [3];

    always #2 clk = ~clk;

    fdet_field_detect dut (
        .clk(clk), .rst(rst), .hsync_n(hsync_n), .vsync_n(vsync_n),
        .field_odd(field_odd), .field_start(field_start)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // one sample: check outputs, drive pins, advance the model
    task automatic tick(input logic v);
        logic h, st;
        @(negedge clk);
        check("R4", field_start, q_start[2]);
        check("R7", field_odd, q_odd[2]);
        if (field_start) starts_seen++;
        h = (ph < HW) ? 1'b0 : 1'b1;
        hsync_n = h;
        vsync_n = v;
        ph = (ph + 1) % LINE;
        st = 1'b0;
        if (m_vprev && !v) begin
            m_since = 0;
            m_pend  = 1'b0;
        end else if (m_since < 1000) begin
            m_since++;
        end
        if (m_hprev && !h && m_since <= LEAD) m_pend = 1'b1;
        m_vrun = v ? 0 : m_vrun + 1;
        if (m_vrun == VMIN) begin
            st = 1'b1;
            m_flag = m_pend;
        end
        m_hprev = h;
        m_vprev = v;
        q_start[2] = q_start[1]; q_start[1] = q_start[0]; q_start[0] = st;
        q_odd[2]   = q_odd[1];   q_odd[1]   = q_odd[0];   q_odd[0]   = m_flag;
    endtask

    // d: samples from VSY fall to next HSY fall (negative: HSY fell first)
    task automatic run_field(input int d, input int vlen);
        int target;
        string req;
        target = ((LINE - d) % LINE + LINE) % LINE;
        tick(1'b1);
        while (ph != target) tick(1'b1);
        starts_seen = 0;
        for (int i = 0; i < vlen; i++) tick(1'b0);
        for (int i = 0; i < 6; i++) tick(1'b1);
        if (vlen >= VMIN) begin
            exp_flag = (d >= 0 && d <= LEAD);
            req = exp_flag ? "R2" : "R3";
            check("R5", starts_seen, 1);
        end else begin
            req = "R6";
            check("R6", starts_seen, 0);
        end
        check(req, field_odd, exp_flag);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3; i++) begin q_start[i] = 1'b0; q_odd[i] = 1'b0; end
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1", field_start, 0);
        check("R1", field_odd, 0);
        rst = 1'b0;
        // directed corners
        run_field(0, 128);          // coincident, exact minimum
        run_field(3, 128);          // one past the window
        run_field(2, 140);          // window edge
        run_field(-1, 150);         // HSY fell first
        run_field(0, 127);          // short after even: held even
        run_field(1, 130);          // odd
        run_field(5, 100);          // short after odd: held odd
        run_field(LINE / 2, 200);   // mid-line even
        run_field(0, LINE + 20);    // long low spanning a line
        run_field(0, 127);          // held odd
        // random fields
        for (int i = 0; i < 40; i++) begin
            int d, len;
            if ($urandom_range(0, 2) == 0) d = int'($urandom_range(0, 4)) - 1;
            else d = int'($urandom_range(0, LINE - 1)) - LINE / 2;
            len = int'($urandom_range(110, 220));
            run_field(d, len);
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule